// File: doc/BRIEF.md
# Four-Channel Byte DMA Controller

This block moves bytes between memory and up to four I/O devices without processor involvement. Software sets it up through an 8-bit register port. Each channel has a 16-bit address register and a 16-bit count register, loaded as two byte writes. There are also per-channel mode settings, a command register, a write-all mask, a software request register and a status register. A channel with an unmasked request asks for the bus on `bus_req` and waits for `bus_grant`. It then runs one byte per clock, asserting its `chan_ack` line together with a memory strobe and the matching device strobe.

A channel can run in one of three request disciplines. In demand mode it keeps the bus while its request input stays high. In single mode it returns the bus after every byte. In block mode one request moves the whole count. The count register holds the number of bytes minus one, and a channel finishes once the byte that finds the count at zero has moved. At that point the channel's terminal-count flag is set, its mask bit is set, and `end_out` pulses.

A memory-to-memory path copies bytes from the channel 0 address to the channel 1 address, two clocks per byte. It can optionally freeze the source address so that a single byte fills a region.

Top module: `dma4_engine`

## Requirements
- R1: After reset `bus_req` is low, `chan_ack` is zero, all terminal-count flags read as zero and all four channel masks are set, so a raised `chan_req` produces no bus request.
- R2: Port offset 2n writes the channel n address and offset 2n+1 writes its count. Each takes the low byte and then the high byte, selected by a shared byte pointer that toggles on every such write. Any write to offset 12 returns the pointer to the low byte.
- R3: A write to offset 15 loads all four masks at once from bits 3:0, where bit n set masks channel n. A masked channel's request input has no effect, so 07h leaves only channel 3 able to run.
- R4: An unmasked request raises `bus_req`. `chan_ack`, the memory strobes and the device strobes stay idle until `bus_grant` is seen. When several channels request in the same cycle, the lowest-numbered channel is served first.
- R5: A channel loaded with count C moves C+1 bytes. Its address steps by +1 per byte, or by -1 when bit 5 of its mode byte is set, wrapping at 16 bits. The mode byte is written at offset 11, and its bits 1:0 name the channel.
- R6: Mode bits 3:2 choose the direction. With 01 each byte asserts `mem_wr` together with `dev_rd`; with 10 each byte asserts `mem_rd` together with `dev_wr`.
- R7: Demand mode (mode bits 7:6 = 00) transfers while the channel request stays high. When the request is low at the end of a byte, the channel releases `bus_req` and keeps the remaining address and count, and a later request resumes from there.
- R8: Single mode (mode bits 7:6 = 01) drops `bus_req` after every byte and requests the bus again if the channel request is still high.
- R9: Block mode (mode bits 7:6 = 10) moves the full count after one request, whether or not the request stays high. A write to offset 9 with bit 2 set raises a software request for the channel in bits 1:0, so 04h starts channel 0.
- R10: When a channel finishes, its terminal-count flag is set, its mask bit is set, `bus_req` falls and `end_out` is high for exactly one cycle.
- R11: A high `end_in` during a byte ends the channel after that byte, with the same effects as reaching the count.
- R12: A read at offset 8 returns the channel request inputs in bits 7:4 and the terminal-count flags in bits 3:0. The read clears the flags.
- R13: Command bit 0 (offset 8 write) turns a channel 0 request into a memory-to-memory copy. Each byte is read at the channel 0 address and written, with the same data, at the channel 1 address, and the channel 1 count governs the length. Command bit 1 freezes the channel 0 address, so 03h fills a region with one byte. No `chan_ack` line is asserted during the copy, and on completion flags 0 and 1 are both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_cs | input | 1 | Register port select |
| io_wr | input | 1 | Register write strobe, one cycle |
| io_rd | input | 1 | Register read strobe, one cycle |
| io_addr | input | 4 | Register offset |
| io_wdata | input | 8 | Register write data |
| io_rdata | output | 8 | Register read data (status at offset 8) |
| chan_req | input | 4 | Per-channel hardware transfer requests |
| bus_req | output | 1 | Request for the system bus |
| bus_grant | input | 1 | Bus granted to this block |
| end_in | input | 1 | External early-termination request |
| end_out | output | 1 | One-cycle pulse when a channel finishes |
| chan_ack | output | 4 | Per-channel transfer acknowledge |
| mem_addr | output | 16 | Memory address of the current byte |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| dev_rd | output | 1 | Device read strobe |
| dev_wr | output | 1 | Device write strobe |
| mem_rdata | input | 8 | Memory read data, used by the copy path |
| mem_wdata | output | 8 | Memory write data for the copy path |

## Verification
The assertions assume that once `bus_grant` rises it stays high for as long as `bus_req` stays high, and that register writes never coincide with an active transfer. The grant model in the stimulus copies `bus_req` onto `bus_grant` one half-cycle later, which meets the first assumption. Every register write is issued only after the bus has been idle for several cycles, which meets the second. Request and `end_in` edges are driven between clock edges, so the cycle in which a demand or early-end stop takes effect is well defined.

// File: rtl/dma4_pkg.sv
package dma4_pkg;

    // Transfer sequencer states
    typedef enum logic [2:0] {
        S_IDLE,
        S_GRANT,
        S_XFER,
        S_CPY_RD,
        S_CPY_WR
    } xfer_state_e;

    // Request discipline field of the mode byte
    localparam logic [1:0] KIND_DEMAND = 2'b00;
    localparam logic [1:0] KIND_SINGLE = 2'b01;
    localparam logic [1:0] KIND_BLOCK  = 2'b10;

    // Direction field of the mode byte
    localparam logic [1:0] DIR_TO_MEM   = 2'b01;
    localparam logic [1:0] DIR_FROM_MEM = 2'b10;

    // Register port offsets above the per-channel address/count pairs
    localparam logic [3:0] OFS_CMD_STAT = 4'h8;
    localparam logic [3:0] OFS_SWREQ    = 4'h9;
    localparam logic [3:0] OFS_MODE     = 4'hB;
    localparam logic [3:0] OFS_PTR_CLR  = 4'hC;
    localparam logic [3:0] OFS_MASK_ALL = 4'hF;

endpackage

// File: rtl/dma4_prio.sv
// Fixed-priority picker: lowest index wins.
module dma4_prio #(
    parameter int N = 4,
    localparam int W = $clog2(N)
) (
    input  logic [N-1:0] req,
    output logic [W-1:0] idx,
    output logic         any
);
    always_comb begin
        idx = '0;
        any = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                idx = W'(i);
                any = 1'b1;
            end
        end
    end
endmodule

// File: rtl/dma4_step.sv
// Next address / count for one channel after one byte.
module dma4_step #(
    parameter int AW = 16
) (
    input  logic [AW-1:0] addr,
    input  logic [AW-1:0] cnt,
    input  logic          dec,
    input  logic          freeze,
    output logic [AW-1:0] addr_nxt,
    output logic [AW-1:0] cnt_nxt,
    output logic          last
);
    always_comb begin
        if (freeze)   addr_nxt = addr;
        else if (dec) addr_nxt = addr - AW'(1);
        else          addr_nxt = addr + AW'(1);
        cnt_nxt = cnt - AW'(1);
        last    = (cnt == '0);
    end
endmodule

// File: rtl/dma4_engine.sv
module dma4_engine
    import dma4_pkg::*;
#(
    parameter int NCH = 4,
    parameter int AW  = 16,
    parameter int DW  = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          io_cs,
    input  logic          io_wr,
    input  logic          io_rd,
    input  logic [3:0]    io_addr,
    input  logic [DW-1:0] io_wdata,
    output logic [DW-1:0] io_rdata,
    input  logic [NCH-1:0] chan_req,
    output logic          bus_req,
    input  logic          bus_grant,
    input  logic          end_in,
    output logic          end_out,
    output logic [NCH-1:0] chan_ack,
    output logic [AW-1:0] mem_addr,
    output logic          mem_rd,
    output logic          mem_wr,
    output logic          dev_rd,
    output logic          dev_wr,
    input  logic [DW-1:0] mem_rdata,
    output logic [DW-1:0] mem_wdata
);
    localparam int CHW = $clog2(NCH);
    localparam logic [3:0] PAIR_END = 4'(2 * NCH);

    typedef struct packed {
        xfer_state_e            st;
        logic [CHW-1:0]         ch;
        logic [NCH-1:0][AW-1:0] addr;
        logic [NCH-1:0][AW-1:0] cnt;
        logic [NCH-1:0]         dec;
        logic [NCH-1:0][1:0]    kind;
        logic [NCH-1:0][1:0]    dir;
        logic                   cpy_en;
        logic                   cpy_fix;
        logic [NCH-1:0]         mask;
        logic [NCH-1:0]         sreq;
        logic [NCH-1:0]         tc;
        logic                   ptr_hi;
        logic [DW-1:0]          hold_byte;
        logic                   fin;
    } regs_t;

    regs_t q, d;

    logic [NCH-1:0]         pend;
    logic [CHW-1:0]         pick;
    logic                   pick_any;
    logic [NCH-1:0][AW-1:0] step_addr;
    logic [NCH-1:0][AW-1:0] step_cnt;
    logic [NCH-1:0]         step_last;
    logic [CHW-1:0]         wsel;
    logic                   stat_rd;

    assign pend    = (chan_req | q.sreq) & ~q.mask;
    assign wsel    = io_addr[CHW:1];
    assign stat_rd = io_cs && io_rd && (io_addr == OFS_CMD_STAT);

    dma4_prio #(.N(NCH)) u_prio (
        .req (pend),
        .idx (pick),
        .any (pick_any)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_step
        dma4_step #(.AW(AW)) u_step (
            .addr     (q.addr[g]),
            .cnt      (q.cnt[g]),
            .dec      (q.dec[g]),
            .freeze   ((g == 0) && q.cpy_en && q.cpy_fix),
            .addr_nxt (step_addr[g]),
            .cnt_nxt  (step_cnt[g]),
            .last     (step_last[g])
        );
    end

    always_comb begin
        d     = q;
        d.fin = 1'b0;

        // Register port writes
        if (io_cs && io_wr) begin
            if (io_addr < PAIR_END) begin
                if (io_addr[0]) begin
                    if (q.ptr_hi) d.cnt[wsel][AW-1:DW] = io_wdata;
                    else          d.cnt[wsel][DW-1:0]  = io_wdata;
                end else begin
                    if (q.ptr_hi) d.addr[wsel][AW-1:DW] = io_wdata;
                    else          d.addr[wsel][DW-1:0]  = io_wdata;
                end
                d.ptr_hi = ~q.ptr_hi;
            end else begin
                case (io_addr)
                    OFS_CMD_STAT: begin
                        d.cpy_en  = io_wdata[0];
                        d.cpy_fix = io_wdata[1];
                    end
                    OFS_SWREQ:    d.sreq[io_wdata[CHW-1:0]] = io_wdata[2];
                    OFS_MODE: begin
                        d.dir[io_wdata[CHW-1:0]]  = io_wdata[3:2];
                        d.dec[io_wdata[CHW-1:0]]  = io_wdata[5];
                        d.kind[io_wdata[CHW-1:0]] = io_wdata[7:6];
                    end
                    OFS_PTR_CLR:  d.ptr_hi = 1'b0;
                    OFS_MASK_ALL: d.mask = io_wdata[NCH-1:0];
                    default: ;
                endcase
            end
        end

        if (stat_rd) d.tc = '0;

        // Transfer sequencer
        case (q.st)
            S_IDLE: begin
                if (pick_any) begin
                    d.st = S_GRANT;
                    d.ch = pick;
                end
            end
            S_GRANT: begin
                if (bus_grant)
                    d.st = (q.cpy_en && (q.ch == '0)) ? S_CPY_RD : S_XFER;
            end
            S_XFER: begin
                d.addr[q.ch] = step_addr[q.ch];
                d.cnt[q.ch]  = step_cnt[q.ch];
                if (step_last[q.ch] || end_in) begin
                    d.tc[q.ch]   = 1'b1;
                    d.mask[q.ch] = 1'b1;
                    d.sreq[q.ch] = 1'b0;
                    d.fin        = 1'b1;
                    d.st         = S_IDLE;
                end else begin
                    case (q.kind[q.ch])
                        KIND_DEMAND: if (!chan_req[q.ch]) d.st = S_IDLE;
                        KIND_SINGLE: d.st = S_IDLE;
                        default: ;
                    endcase
                end
            end
            S_CPY_RD: begin
                d.hold_byte = mem_rdata;
                d.st        = S_CPY_WR;
            end
            S_CPY_WR: begin
                d.addr[0] = step_addr[0];
                d.addr[1] = step_addr[1];
                d.cnt[1]  = step_cnt[1];
                if (step_last[1] || end_in) begin
                    d.tc[1:0]   = 2'b11;
                    d.mask[1:0] = 2'b11;
                    d.sreq[0]   = 1'b0;
                    d.fin       = 1'b1;
                    d.st        = S_IDLE;
                end else begin
                    d.st = S_CPY_RD;
                end
            end
            default: d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.st   <= S_IDLE;
            q.mask <= '1;
        end else begin
            q <= d;
        end
    end

    // Outputs decoded from registered state
    always_comb begin
        bus_req   = (q.st != S_IDLE);
        end_out   = q.fin;
        chan_ack  = '0;
        mem_addr  = '0;
        mem_rd    = 1'b0;
        mem_wr    = 1'b0;
        dev_rd    = 1'b0;
        dev_wr    = 1'b0;
        mem_wdata = '0;
        io_rdata  = stat_rd ? DW'({chan_req, q.tc}) : '0;
        case (q.st)
            S_XFER: begin
                chan_ack[q.ch] = 1'b1;
                mem_addr       = q.addr[q.ch];
                mem_wr         = (q.dir[q.ch] == DIR_TO_MEM);
                dev_rd         = (q.dir[q.ch] == DIR_TO_MEM);
                mem_rd         = (q.dir[q.ch] == DIR_FROM_MEM);
                dev_wr         = (q.dir[q.ch] == DIR_FROM_MEM);
            end
            S_CPY_RD: begin
                mem_addr = q.addr[0];
                mem_rd   = 1'b1;
            end
            S_CPY_WR: begin
                mem_addr  = q.addr[1];
                mem_wr    = 1'b1;
                mem_wdata = q.hold_byte;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/dma4_engine_chk.sv
module dma4_engine_chk #(
    parameter int NCH = 4
) (
    input logic           clk,
    input logic           rst_n,
    input logic           bus_req,
    input logic           bus_grant,
    input logic [NCH-1:0] chan_ack,
    input logic           mem_rd,
    input logic           mem_wr,
    input logic           dev_rd,
    input logic           dev_wr,
    input logic           end_out
);
    // R4: at most one channel acknowledged
    a_r4_ack_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(chan_ack));

    // R4: acknowledge only while the bus is requested and was granted
    a_r4_ack_with_req: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_ack != '0) |-> bus_req);

    a_r4_ack_after_grant: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_ack != '0) |-> $past(bus_grant));

    // R6: device strobe always paired with the opposite memory strobe
    a_r6_devrd_pair: assert property (@(posedge clk) disable iff (!rst_n)
        dev_rd |-> (mem_wr && !mem_rd));

    a_r6_devwr_pair: assert property (@(posedge clk) disable iff (!rst_n)
        dev_wr |-> (mem_rd && !mem_wr));

    // R10: finish pulse lasts one cycle and the bus is already released
    a_r10_end_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        end_out |=> !end_out);

    a_r10_end_releases: assert property (@(posedge clk) disable iff (!rst_n)
        end_out |-> !bus_req);

    // R13: memory write without a device strobe is a copy: no acknowledge
    a_r13_copy_no_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr && !dev_rd) |-> (chan_ack == '0));

endmodule

bind dma4_engine dma4_engine_chk #(.NCH(NCH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_req   (bus_req),
    .bus_grant (bus_grant),
    .chan_ack  (chan_ack),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr),
    .dev_rd    (dev_rd),
    .dev_wr    (dev_wr),
    .end_out   (end_out)
);

// File: tb/dma4_engine_tb.sv
module dma4_engine_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        io_cs = 1'b0, io_wr = 1'b0, io_rd = 1'b0;
    logic [3:0]  io_addr = '0;
    logic [7:0]  io_wdata = '0;
    logic [7:0]  io_rdata;
    logic [3:0]  chan_req = '0;
    logic        bus_req;
    logic        bus_grant = 1'b0;
    logic        end_in = 1'b0;
    logic        end_out;
    logic [3:0]  chan_ack;
    logic [15:0] mem_addr;
    logic        mem_rd, mem_wr, dev_rd, dev_wr;
    logic [7:0]  mem_rdata;
    logic [7:0]  mem_wdata;

    always #10 clk = ~clk;

    // Memory model: data is a fixed function of the address
    assign mem_rdata = mem_addr[7:0] ^ 8'h5A;

    dma4_engine dut_i (
        .clk(clk), .rst_n(rst_n), .io_cs(io_cs), .io_wr(io_wr), .io_rd(io_rd),
        .io_addr(io_addr), .io_wdata(io_wdata), .io_rdata(io_rdata),
        .chan_req(chan_req), .bus_req(bus_req), .bus_grant(bus_grant),
        .end_in(end_in), .end_out(end_out), .chan_ack(chan_ack),
        .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .dev_rd(dev_rd), .dev_wr(dev_wr), .mem_rdata(mem_rdata),
        .mem_wdata(mem_wdata)
    );

    int n_chk = 0, n_err = 0;

    // Monitor counters (cumulative, owned by the monitor)
    int n_ack = 0, n_memwr = 0, n_memrd = 0, n_devrd = 0, n_devwr = 0;
    int n_end = 0, n_fall = 0, n_moved = 0;
    int n_ch [4] = '{0, 0, 0, 0};
    logic [15:0] first_addr = '0, last_addr = '0, rd_first = '0, wr_last = '0;
    logic [3:0]  first_ack = '0;
    logic [7:0]  wdata_last = '0;
    logic        prev_req = 1'b0;
    // Baselines (owned by the test)
    int b_ack = 0, b_memwr = 0, b_memrd = 0, b_devrd = 0, b_devwr = 0;
    int b_end = 0, b_fall = 0, b_moved = 0;
    int b_ch [4] = '{0, 0, 0, 0};

    initial forever begin
        @(negedge clk);
        if (chan_ack != 4'h0) begin
            if (n_ack == b_ack) begin
                first_addr = mem_addr;
                first_ack  = chan_ack;
            end
            last_addr = mem_addr;
            n_ack++;
            for (int c = 0; c < 4; c++) if (chan_ack[c]) n_ch[c]++;
        end
        if (mem_wr) begin
            n_memwr++;
            wr_last    = mem_addr;
            wdata_last = mem_wdata;
        end
        if (mem_rd) begin
            if (n_memrd == b_memrd) rd_first = mem_addr;
            else if (mem_addr != rd_first) n_moved++;
            n_memrd++;
        end
        if (dev_rd) n_devrd++;
        if (dev_wr) n_devwr++;
        if (end_out) n_end++;
        if (prev_req && !bus_req) n_fall++;
        prev_req  = bus_req;
        bus_grant = bus_req;  // bus arbiter model
    end

    task automatic snap();
        b_ack = n_ack; b_memwr = n_memwr; b_memrd = n_memrd; b_devrd = n_devrd;
        b_devwr = n_devwr; b_end = n_end; b_fall = n_fall; b_moved = n_moved;
        for (int c = 0; c < 4; c++) b_ch[c] = n_ch[c];
    endtask

    task automatic check(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] v);
        @(negedge clk);
        io_cs = 1'b1; io_wr = 1'b1; io_addr = a; io_wdata = v;
        @(negedge clk);
        io_cs = 1'b0; io_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] v);
        @(negedge clk);
        io_cs = 1'b1; io_rd = 1'b1; io_addr = a;
        #1 v = io_rdata;
        @(negedge clk);
        io_cs = 1'b0; io_rd = 1'b0;
    endtask

    task automatic prog(input int ch, input logic [15:0] a, input logic [15:0] c,
                        input logic [7:0] mode);
        wr(4'hC, 8'h00);
        wr(4'(2 * ch), a[7:0]);
        wr(4'(2 * ch), a[15:8]);
        wr(4'(2 * ch + 1), c[7:0]);
        wr(4'(2 * ch + 1), c[15:8]);
        wr(4'hB, mode);
    endtask

    task automatic wait_quiet();
        int idle = 0;
        while (idle < 4) begin
            @(negedge clk); #1;
            if (!bus_req) idle++; else idle = 0;
        end
    endtask

    task automatic wait_bytes(input int k);
        while (n_ack - b_ack < k) begin
            @(negedge clk); #1;
        end
    endtask

    // mode(8) start(16) count(16) last address(16)
    localparam logic [55:0] VECS [4] = '{
        56'h84_1000_0004_1004,
        56'hA9_2000_0002_1FFE,
        56'h86_FFFE_0003_0001,
        56'h8B_0500_0000_0500
    };

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual=hung expected=finished");
        summary();
        $finish;
    end

    initial begin
        logic [7:0]  s;
        logic [7:0]  md;
        logic [15:0] sa, cn, la;
        int          ch, nb;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;

        // R1 reset state
        check("R1 bus_req after reset", bus_req, 0);
        check("R1 chan_ack after reset", chan_ack, 0);
        rd(4'h8, s);
        check("R1 status after reset", s, 8'h00);
        chan_req = 4'b0100;
        repeat (6) @(negedge clk);
        #1 check("R1 masked at reset, no bus request", bus_req, 0);
        rd(4'h8, s);
        check("R12 request bits in status", s, 8'h40);
        chan_req = 4'b0000;

        // Table: block transfers by software request (R5 R6 R9 R10 R12)
        for (int i = 0; i < 4; i++) begin
            md = VECS[i][55:48]; sa = VECS[i][47:32];
            cn = VECS[i][31:16]; la = VECS[i][15:0];
            ch = int'(md[1:0]); nb = int'(cn) + 1;
            prog(ch, sa, cn, md);
            wr(4'h8, 8'h00);
            wr(4'hF, 8'h00);
            snap();
            wr(4'h9, {5'b00001, md[1:0]});
            wait_quiet();
            check("R5 R9 byte count", n_ack - b_ack, nb);
            check("R5 first address", first_addr, sa);
            check("R5 last address", last_addr, la);
            check("R6 mem_wr count", n_memwr - b_memwr, (md[3:2] == 2'b01) ? nb : 0);
            check("R6 dev_rd count", n_devrd - b_devrd, (md[3:2] == 2'b01) ? nb : 0);
            check("R6 mem_rd count", n_memrd - b_memrd, (md[3:2] == 2'b10) ? nb : 0);
            check("R6 dev_wr count", n_devwr - b_devwr, (md[3:2] == 2'b10) ? nb : 0);
            check("R10 end pulse count", n_end - b_end, 1);
            rd(4'h8, s);
            check("R10 R12 terminal flag", s, 8'(1 << ch));
            rd(4'h8, s);
            check("R12 flags cleared by read", s, 8'h00);
        end

        // R2 byte pointer and its clear command
        wr(4'hC, 8'h00);
        wr(4'h0, 8'h34);
        wr(4'hC, 8'h00);
        wr(4'h0, 8'h78);
        wr(4'h0, 8'h12);
        wr(4'h1, 8'h00);
        wr(4'h1, 8'h00);
        wr(4'hB, 8'h84);
        wr(4'hF, 8'h00);
        snap();
        wr(4'h9, 8'h04);
        wait_quiet();
        check("R2 address after pointer clear", first_addr, 16'h1278);
        check("R2 one byte", n_ack - b_ack, 1);
        rd(4'h8, s);

        // R3 write-all mask: only channel 3 enabled
        prog(2, 16'h0200, 16'h0000, 8'h86);
        prog(3, 16'h0300, 16'h0000, 8'h8B);
        wr(4'hF, 8'h07);
        snap();
        @(negedge clk) chan_req = 4'b1100;
        wait_quiet();
        check("R3 masked channel 2 ignored", n_ch[2] - b_ch[2], 0);
        check("R3 channel 3 served", n_ch[3] - b_ch[3], 1);
        chan_req = 4'b0000;
        rd(4'h8, s);

        // R4 handshake and fixed priority
        prog(1, 16'h0100, 16'h0000, 8'h85);
        prog(2, 16'h0200, 16'h0000, 8'h86);
        wr(4'hF, 8'h00);
        snap();
        @(negedge clk) chan_req = 4'b0110;
        @(negedge clk); #1;
        check("R4 bus_req raised", bus_req, 1);
        check("R4 no ack before grant", chan_ack, 0);
        wait_quiet();
        check("R4 lowest channel first", first_ack, 4'b0010);
        check("R4 both channels served", (n_ch[1] - b_ch[1]) + (n_ch[2] - b_ch[2]), 2);
        chan_req = 4'b0000;
        rd(4'h8, s);

        // R7 demand mode: stop on request drop, then resume
        prog(1, 16'h0A00, 16'h0007, 8'h05);
        wr(4'hF, 8'h00);
        snap();
        @(negedge clk) chan_req = 4'b0010;
        wait_bytes(3);
        chan_req = 4'b0000;
        wait_quiet();
        check("R7 bytes before request drop", n_ack - b_ack, 3);
        rd(4'h8, s);
        check("R7 no terminal flag after pause", s, 8'h00);
        snap();
        @(negedge clk) chan_req = 4'b0010;
        wait_quiet();
        check("R7 remaining bytes", n_ack - b_ack, 5);
        check("R7 resumed address", first_addr, 16'h0A03);
        rd(4'h8, s);
        check("R7 finished flag with request", s, 8'h22);
        chan_req = 4'b0000;

        // R8 single mode: bus released after each byte
        prog(2, 16'h0C00, 16'h0002, 8'h46);
        wr(4'hF, 8'h00);
        snap();
        @(negedge clk) chan_req = 4'b0100;
        wait_quiet();
        check("R8 bytes", n_ack - b_ack, 3);
        check("R8 bus released per byte", n_fall - b_fall, 3);
        repeat (4) @(negedge clk);
        #1 check("R10 mask stops held request", bus_req, 0);
        chan_req = 4'b0000;
        rd(4'h8, s);
        check("R8 terminal flag", s, 8'h04);

        // R11 external end
        prog(0, 16'h0E00, 16'h0009, 8'h84);
        wr(4'hF, 8'h00);
        snap();
        wr(4'h9, 8'h04);
        wait_bytes(2);
        end_in = 1'b1;
        @(negedge clk) end_in = 1'b0;
        wait_quiet();
        check("R11 bytes before external end", n_ack - b_ack, 2);
        check("R11 end pulse", n_end - b_end, 1);
        rd(4'h8, s);
        check("R11 terminal flag", s, 8'h01);

        // R13 memory fill with held source
        prog(0, 16'h3000, 16'h0000, 8'h88);
        prog(1, 16'h4000, 16'h0003, 8'h85);
        wr(4'h8, 8'h03);
        wr(4'hF, 8'h0E);
        snap();
        wr(4'h9, 8'h04);
        wait_quiet();
        check("R13 fill writes", n_memwr - b_memwr, 4);
        check("R13 fill last destination", wr_last, 16'h4003);
        check("R13 source held", n_moved - b_moved, 0);
        check("R13 source address", rd_first, 16'h3000);
        check("R13 fill data", wdata_last, 8'h5A);
        check("R13 no acknowledge", n_ack - b_ack, 0);
        rd(4'h8, s);
        check("R13 flags 0 and 1", s, 8'h03);

        // R13 copy with moving source
        prog(0, 16'h3010, 16'h0000, 8'h88);
        prog(1, 16'h4010, 16'h0002, 8'h85);
        wr(4'h8, 8'h01);
        wr(4'hF, 8'h0E);
        snap();
        wr(4'h9, 8'h04);
        wait_quiet();
        check("R13 copy writes", n_memwr - b_memwr, 3);
        check("R13 copy last destination", wr_last, 16'h4012);
        check("R13 copy source moved", n_moved - b_moved, 2);
        check("R13 copy data", wdata_last, 8'h48);
        wr(4'h8, 8'h00);

        summary();
        $finish;
    end
endmodule